// File: doc/BRIEF.md
# HDLC Modem Handshake Controller

This block sits beside a serial HDLC transmitter and runs the two modem control lines. It drives an active-low request-to-send line, either held on permanently or shaped around each frame and switched on the chosen edge of the transmit clock. It also gates the start of every frame with a clear-to-send condition.

The clear-to-send condition can be ignored, or taken from one of two sources: the external active-low pin, after a two-flop synchronizer, or a signal made elsewhere on chip. If clear-to-send drops while a frame is on the line, a policy bit decides what happens. The frame either runs to its end, or the controller raises an abort request towards the transmitter and issues a single-cycle interrupt pulse.

All configuration arrives on plain input ports. Every register runs on the transmit clock, except one capture flop that runs on its falling edge.

Top module: `hdlc_mdm_hs`

## Requirements
- R1: With `cfg_rts_en`=0, `rts_n` is 0 in every cycle, whatever the frame status.
- R2: With `cfg_rts_en`=1 and `cfg_rts_fall`=0, `rts_n` equals the inverse of `frame_act` as sampled at the most recent rising clock edge.
- R3: With `cfg_rts_en`=1 and `cfg_rts_fall`=1, `rts_n` equals the inverse of `frame_act` as sampled at the most recent falling clock edge.
- R4: With `cfg_cts_en`=0, `tx_permit` = `frame_pend` AND NOT `frame_act` AND NOT `tx_abort`, regardless of `cts_pin_n` and `cts_int`.
- R5: With `cfg_cts_en`=1 and `cfg_cts_int`=0, the effective CTS is the inverse of `cts_pin_n` delayed by two rising edges. `tx_permit` additionally requires that the effective CTS is 1.
- R6: With `cfg_cts_en`=1 and `cfg_cts_int`=1, the effective CTS is `cts_int` taken combinationally, and `cts_pin_n` has no effect.
- R7: With `cfg_cts_stop`=0, a loss of the effective CTS during `frame_act` raises neither `tx_abort` nor `cts_lost_irq`.
- R8: With `cfg_cts_en`=1 and `cfg_cts_stop`=1, a rising edge that samples `frame_act`=1 with the effective CTS at 0 sets `tx_abort` from the next cycle. `tx_abort` stays set until a rising edge samples `frame_act`=0. `cts_lost_irq` is 1 for exactly the one cycle after the setting edge.
- R9: `cts_lost_irq` fires at most once per frame, even if CTS recovers and drops again, and `tx_permit` is 0 while `tx_abort` is 1.
- R10: During and just after reset, `tx_abort`=0 and `cts_lost_irq`=0. The synchronizer holds the pin as deasserted, and the edge capture flops hold "no frame".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rts_en | input | 1 | 1: shape RTS per frame; 0: RTS always asserted |
| cfg_rts_fall | input | 1 | 1: RTS changes on falling edge; 0: rising edge |
| cfg_cts_en | input | 1 | 1: qualify transmission with CTS |
| cfg_cts_int | input | 1 | CTS source: 0 external pin, 1 internal signal |
| cfg_cts_stop | input | 1 | 1: abort frame on CTS loss; 0: finish frame |
| cts_pin_n | input | 1 | External clear-to-send, active low, asynchronous |
| cts_int | input | 1 | Internal clear-to-send, active high |
| frame_pend | input | 1 | Transmitter has a frame waiting |
| frame_act | input | 1 | Transmitter is sending a frame |
| rts_n | output | 1 | Request-to-send, active low |
| tx_permit | output | 1 | Transmitter may start the pending frame |
| tx_abort | output | 1 | Request to stop the current frame |
| cts_lost_irq | output | 1 | One-cycle pulse on CTS loss abort |

## Verification
The in-module assertions watch, on every rising edge, several rules. They check the rising-edge RTS timing, the single-cycle width of the interrupt and its pairing with the abort request, and that an abort starts only under the stop policy. They also check that the abort clears once the frame ends, and that an internal-source permit never appears without internal CTS. Other behaviour can only be shown by the bench's scenarios. This covers falling-edge RTS capture, the two-edge synchronizer latency, the pin being ignored in internal mode, the once-per-frame interrupt across repeated CTS glitches, and reset values. It is checked against a cycle model driven by random frame and CTS activity.

// File: rtl/hdlc_mdm_hs.sv
module hdlc_mdm_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_rts_en,
  input  logic cfg_rts_fall,
  input  logic cfg_cts_en,
  input  logic cfg_cts_int,
  input  logic cfg_cts_stop,
  input  logic cts_pin_n,
  input  logic cts_int,
  input  logic frame_pend,
  input  logic frame_act,
  output logic rts_n,
  output logic tx_permit,
  output logic tx_abort,
  output logic cts_lost_irq
);

  logic pin_s1, pin_s2;
  logic act_rise, act_fall;
  logic abort_q, irq_q;
  logic cts_eff, cts_loss;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_s1 <= 1'b1;
      pin_s2 <= 1'b1;
    end else begin
      pin_s1 <= cts_pin_n;
      pin_s2 <= pin_s1;
    end

  assign cts_eff = !cfg_cts_en ? 1'b1 : (cfg_cts_int ? cts_int : ~pin_s2);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) act_rise <= 1'b0;
    else        act_rise <= frame_act;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) act_fall <= 1'b0;
    else        act_fall <= frame_act;

  assign rts_n = cfg_rts_en ? ~(cfg_rts_fall ? act_fall : act_rise) : 1'b0;

  assign cts_loss = cfg_cts_en & cfg_cts_stop & frame_act & ~cts_eff & ~abort_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      abort_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= cts_loss;
      if (!frame_act)    abort_q <= 1'b0;
      else if (cts_loss) abort_q <= 1'b1;
    end

  assign tx_abort     = abort_q;
  assign cts_lost_irq = irq_q;
  assign tx_permit    = frame_pend & ~frame_act & ~abort_q & cts_eff;

  // R2
  rts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && cfg_rts_en && !cfg_rts_fall |-> (rts_n == !$past(frame_act)));

  // R8
  irq_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cts_lost_irq |=> !cts_lost_irq);

  // R8
  irq_with_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cts_lost_irq |-> tx_abort);

  // R7
  abort_policy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_abort) |-> $past(cfg_cts_stop && cfg_cts_en && frame_act));

  // R8
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort && !frame_act |=> !tx_abort);

  // R6
  int_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cts_en && cfg_cts_int && tx_permit |-> cts_int);

  // R9
  permit_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> !tx_permit);

endmodule

// File: tb/sim_hdlc_mdm_hs.sv
module sim_hdlc_mdm_hs;
  localparam int CLK_PER = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_rts_en = 0, cfg_rts_fall = 0, cfg_cts_en = 0, cfg_cts_int = 0, cfg_cts_stop = 0;
  logic cts_pin_n = 1, cts_int = 0, frame_pend = 0, frame_act = 0;
  logic rts_n, tx_permit, tx_abort, cts_lost_irq;

  int n_run = 0, n_fail = 0;
  logic m_s1 = 1, m_s2 = 1, m_r = 0, m_abort = 0, m_irq = 0;
  bit   done = 0;

  always #(CLK_PER/2) clk = ~clk;

  hdlc_mdm_hs u0 (.clk, .rst_n, .cfg_rts_en, .cfg_rts_fall, .cfg_cts_en, .cfg_cts_int,
    .cfg_cts_stop, .cts_pin_n, .cts_int, .frame_pend, .frame_act,
    .rts_n, .tx_permit, .tx_abort, .cts_lost_irq);

  task automatic chk(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t got %b expected %b", req, $time, act, exp);
    end
  endtask

  function automatic logic eff_cts();
    return !cfg_cts_en ? 1'b1 : (cfg_cts_int ? cts_int : ~m_s2);
  endfunction

  function automatic logic exp_rts();
    if (!cfg_rts_en) return 1'b0;
    return cfg_rts_fall ? ~frame_act : ~m_r;
  endfunction

  task automatic model_edge();
    logic loss;
    loss = cfg_cts_en & cfg_cts_stop & frame_act & ~eff_cts() & ~m_abort;
    m_irq = loss;
    if (!frame_act) m_abort = 0; else if (loss) m_abort = 1;
    m_s2 = m_s1; m_s1 = cts_pin_n; m_r = frame_act;
  endtask

  task automatic check_all();
    string rq, pq;
    rq = !cfg_rts_en ? "R1" : (cfg_rts_fall ? "R3" : "R2");
    pq = !cfg_cts_en ? "R4" : (cfg_cts_int ? "R6" : "R5");
    chk(rq, rts_n, exp_rts());
    chk(pq, tx_permit, frame_pend & ~frame_act & ~m_abort & eff_cts());
    chk(cfg_cts_stop ? "R8" : "R7", tx_abort, m_abort);
    chk(cfg_cts_stop ? "R8" : "R7", cts_lost_irq, m_irq);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    #1;
  endtask

  initial begin
    int irqs;
    void'($urandom(32'h5EED1));
    #(CLK_PER*3 + 1);
    // R10 reset state
    chk("R10", tx_abort, 1'b0);
    chk("R10", cts_lost_irq, 1'b0);
    chk("R10", tx_permit, 1'b0);
    chk("R10", rts_n, 1'b0);
    cfg_rts_en = 1; #1;
    chk("R10", rts_n, 1'b1);
    @(negedge clk); #1 rst_n = 1;
    @(posedge clk); #1;

    // R9 directed: one frame, CTS glitches twice, stop mode, internal source
    cfg_cts_en = 1; cfg_cts_int = 1; cfg_cts_stop = 1; cts_int = 1;
    frame_pend = 1; #7; check_all(); chk("R6", tx_permit, 1'b1);
    cyc(); frame_act = 1; frame_pend = 0; #7; check_all();
    irqs = 0;
    for (int i = 0; i < 12; i++) begin
      cyc(); cts_int = (i % 4 == 1) ? 0 : 1; #7; check_all();
      if (cts_lost_irq) irqs++;
    end
    cyc(); frame_act = 0; #7; check_all();
    cyc(); #7; check_all();
    if (cts_lost_irq) irqs++;
    chk("R9", tx_abort, 1'b0);
    n_run++;
    if (irqs != 1) begin n_fail++; $display("FAIL R9 irq count got %0d expected 1", irqs); end

    // R6 directed: pin ignored in internal mode
    cts_int = 1; frame_pend = 1;
    for (int i = 0; i < 4; i++) begin cyc(); cts_pin_n = 1; #7; check_all(); end
    chk("R6", tx_permit, 1'b1);

    // R5 directed: two-edge latency
    cfg_cts_int = 0; cts_pin_n = 1;
    for (int i = 0; i < 3; i++) begin cyc(); #7; check_all(); end
    cyc(); cts_pin_n = 0; #7; check_all(); chk("R5", tx_permit, 1'b0);
    cyc(); #7; check_all(); chk("R5", tx_permit, 1'b0);
    cyc(); #7; check_all(); chk("R5", tx_permit, 1'b1);

    // random
    for (int i = 0; i < 6000; i++) begin
      cyc();
      if (i % 150 == 0) begin
        cfg_rts_en = $urandom; cfg_rts_fall = $urandom; cfg_cts_en = ($urandom % 4) != 0;
        cfg_cts_int = $urandom; cfg_cts_stop = $urandom;
      end
      if ($urandom % 10 == 0) frame_act = ~frame_act;
      if ($urandom % 6 == 0)  frame_pend = $urandom;
      if ($urandom % 7 == 0)  cts_pin_n = $urandom;
      if ($urandom % 7 == 0)  cts_int = $urandom;
      #7; check_all();
    end
    done = 1;
  end

  initial begin
    #(CLK_PER*100000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    done = 1;
  end

  initial begin
    wait (done);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule